// File: doc/BRIEF.md
# I2C Power-Management Register Controller

This block is an I2C target that sits on a board-management bus and controls the power-related outputs of a console-style system. A bus master addresses it at 7-bit address 0x50 and sends one index byte. Some index values are commands. A command acts as soon as its index byte is acknowledged and carries no data. The other index values select a one-byte register. After the index, the master either writes one data byte in the same transfer, or issues a repeated START with the read bit set and reads one byte.

The commands switch drive power on and off, and start fixed-length pulses for the drive eject request and for three radio-module resets. Other commands set each of the three front-panel LEDs to off, steady or blinking. The registers hold the USB port power enables and the notification LED enables, and provide an edge-latched event flag byte with write-one-to-clear. A 16-byte error block is committed only when written from its top address downward. There is also a 128-byte scratch area and a few read-only identity bytes.

The bus side cannot be stalled, because the controller never stretches SCL. For that reason the internal byte strobes from the bus engine to the register map are single-cycle valid pulses with no ready. The register map always accepts a strobe in the cycle it arrives.

Top module: `pwr_mgmt_i2c`

## Requirements
- R1: The target acknowledges only address byte 0x50 (0xA0 for write, 0xA1 for read). For any other address it leaves SDA released for the rest of that transfer.
- R2: Index 0x00 sets `odd_pwr` to 1 and index 0x01 clears it, both on the index byte alone with no data byte. `odd_pwr` is 0 after reset.
- R3: A read of any command index (0x00–0x02, 0x10, 0x12–0x16, 0x1E, 0x1F, 0x20–0x22) returns 0xFF. An undefined index (for example 0x30) reads 0x00 and ignores writes.
- R4: Index 0x02 pulses `odd_eject`. Indices 0x20, 0x21 and 0x22 pulse `radio_rst[0]`, `radio_rst[1]` and `radio_rst[2]` respectively. Each pulse is high for exactly PULSE_LEN (16) clock cycles, and a new trigger during an active pulse is ignored.
- R5: LED commands set the LED outputs as follows. `led_pwr` is on for 0x10, off for 0x12 and blinking for 0x13. `led_aux` is off for 0x14, on for 0x15 and blinking for 0x16. `led_stby` is on for 0x1E and blinking for 0x1F. Blinking toggles every BLINK_DIV clocks, and all three LEDs are off after reset.
- R6: Index 0x40 reads 0xC5, 0x47 reads 0xFF and 0x48 reads 0x0F. Writes to these indices have no effect.
- R7: Register 0x41 holds event flags in bits 6..0, in this order: power button, eject button, disc insert, timer, radio interrupt, wake0, wake1. These map to `evt_in[6:0]`. A flag sets on a rising edge of its synchronized input, and writing 1 to a bit clears it.
- R8: Register 0x43 bit 0 drives `usb_en[0]` (front port) and bit 1 drives `usb_en[1]` (rear port). Bits 7..2 read as 0.
- R9: Register 0x44 is a full read/write byte. Its enable/blink pairs are bits 5:4 for blue (`notif_led[2]`), 3:2 for red (`notif_led[1]`) and 1:0 for yellow (`notif_led[0]`). An LED is lit when its enable bit is set, and it blinks when its blink bit is also set.
- R10: Writes to 0x60–0x6F land in a shadow buffer, and reads return the live bytes. The shadow buffer is copied to the live bytes only when 0x60 is written after 0x6F, 0x6E, …, 0x61 were written in strictly descending order. Any other order discards the sequence.
- R11: Indices 0x80–0xFF are independent read/write scratch bytes that reset to 0x00.
- R12: The target changes its SDA drive only while SCL is low, and it has no SCL output.
- R13: Each write transfer accepts one data byte. A second data byte in the same transfer is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| evt_in | input | 7 | Raw event inputs, bit order as register 0x41 |
| odd_pwr | output | 1 | Optical drive power enable |
| odd_eject | output | 1 | Drive eject request pulse |
| radio_rst | output | 3 | Radio reset pulses: bit 0 Bluetooth, bit 1 Wi-Fi, bit 2 controller link |
| led_pwr | output | 1 | Power LED drive |
| led_aux | output | 1 | Second status LED drive |
| led_stby | output | 1 | Standby LED drive |
| notif_led | output | 3 | Notification LEDs: bit 2 blue, bit 1 red, bit 0 yellow |
| usb_en | output | 2 | USB power enables: bit 0 front, bit 1 rear |

## Verification
The checker watches four properties on every cycle:
- No reset or eject pulse stays high for more than PULSE_LEN cycles.
- SDA drive never changes while SCL is high.
- The drive power level and the USB enables change only in the cycle after the matching command or register strobe.
- An event flag falls only after a write to the flag register.

Several behaviours need whole bus transfers and can only be shown by the bench scenarios. These are the address filtering, 0xFF on command reads, the identity constants, blink versus steady LED modes, edge-only event latching, the descending-order commit of the error block and its rejection of broken sequences, and the NACK of a second data byte.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ERR_BYTES = 16;
  localparam int SCR_BYTES = 128;
  localparam int N_PULSE   = 4;   // eject + three radio resets

  typedef enum logic [1:0] {LED_OFF = 2'd0, LED_ON = 2'd1, LED_BLINK = 2'd2} led_mode_t;
  typedef enum logic [2:0] {T_IDLE, T_RX, T_ACK, T_TXW, T_TX, T_RACK} tgt_state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_DATA, PH_EXTRA} tgt_phase_t;

  function automatic logic is_cmd(input logic [7:0] ix);
    case (ix)
      8'h00, 8'h01, 8'h02, 8'h10, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
      8'h1E, 8'h1F, 8'h20, 8'h21, 8'h22: is_cmd = 1'b1;
      default:                           is_cmd = 1'b0;
    endcase
  endfunction

  function automatic logic led_drive(input led_mode_t m, input logic blink);
    led_drive = (m == LED_ON) || ((m == LED_BLINK) && blink);
  endfunction
endpackage

// File: rtl/pmc_pulse.sv
module pmc_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (trig && cnt == '0)    cnt <= CW'(LEN);
    else if (cnt != '0)            cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/pmc_blink.sv
module pmc_blink #(
  parameter int DIV = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      blink   <= 1'b0;
    end else if (div_cnt == DW'(DIV - 1)) begin
      div_cnt <= '0;
      blink   <= ~blink;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pmc_i2c_tgt.sv
module pmc_i2c_tgt
  import pmc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       idx_vld,
  output logic       wr_vld,
  output logic [7:0] wr_data,
  output logic [7:0] reg_idx,
  input  logic [7:0] rd_data
);
  logic [2:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_c, stop_c;

  tgt_state_t state;
  tgt_phase_t phase;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, txsh, rx_byte;
  logic ack_q, drv, rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign scl_s    = scl_sh[1];
  assign scl_p    = scl_sh[2];
  assign sda_s    = sda_sh[1];
  assign sda_p    = sda_sh[2];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign rx_byte  = {shreg[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= T_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ack_q   <= 1'b0;
      drv     <= 1'b0;
      rw_q    <= 1'b0;
      idx_vld <= 1'b0;
      wr_vld  <= 1'b0;
      wr_data <= '0;
      reg_idx <= '0;
    end else begin
      idx_vld <= 1'b0;
      wr_vld  <= 1'b0;
      if (start_c) begin
        state   <= T_RX;
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        drv     <= 1'b0;
      end else if (stop_c) begin
        state <= T_IDLE;
        drv   <= 1'b0;
      end else begin
        case (state)
          T_RX: if (scl_rise) begin
            shreg <= rx_byte;
            if (bit_cnt == 4'd7) begin
              bit_cnt <= '0;
              drv     <= 1'b0;
              state   <= T_ACK;
              case (phase)
                PH_ADDR: begin
                  ack_q <= (rx_byte[7:1] == DEV_ADDR);
                  rw_q  <= rx_byte[0];
                end
                PH_IDX: begin
                  ack_q   <= 1'b1;
                  reg_idx <= rx_byte;
                  idx_vld <= 1'b1;
                end
                PH_DATA: begin
                  ack_q   <= 1'b1;
                  wr_data <= rx_byte;
                  wr_vld  <= 1'b1;
                end
                default: ack_q <= 1'b0;
              endcase
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          T_ACK: if (scl_fall) begin
            if (!drv) begin
              drv <= 1'b1;
              if (!ack_q) state <= T_IDLE;
            end else begin
              drv <= 1'b0;
              if (phase == PH_ADDR && rw_q) begin
                txsh    <= rd_data;
                bit_cnt <= '0;
                state   <= T_TX;
              end else begin
                state <= T_RX;
                case (phase)
                  PH_ADDR: phase <= PH_IDX;
                  PH_IDX:  phase <= PH_DATA;
                  default: phase <= PH_EXTRA;
                endcase
              end
            end
          end
          T_TX: begin
            if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
            if (scl_fall) begin
              if (bit_cnt == 4'd8) state <= T_RACK;
              else                 txsh  <= {txsh[6:0], 1'b0};
            end
          end
          T_RACK: if (scl_rise) state <= sda_s ? T_IDLE : T_TXW;
          T_TXW: if (scl_fall) begin
            txsh    <= rd_data;
            bit_cnt <= '0;
            state   <= T_TX;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    sda_oe = 1'b0;
    if (state == T_ACK && drv && ack_q) sda_oe = 1'b1;
    if (state == T_TX && !txsh[7])      sda_oe = 1'b1;
  end
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  parameter int BLINK_DIV = 1 << 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_vld,
  input  logic       wr_vld,
  input  logic [7:0] wr_data,
  input  logic [7:0] reg_idx,
  output logic [7:0] rd_data,
  input  logic [6:0] evt_in,
  output logic [6:0] evt_flags,
  output logic       odd_pwr,
  output logic       odd_eject,
  output logic [2:0] radio_rst,
  output logic       led_pwr,
  output logic       led_aux,
  output logic       led_stby,
  output logic [2:0] notif_led,
  output logic [1:0] usb_en
);
  led_mode_t pwr_mode, aux_mode, stby_mode;
  logic [7:0] notif_q;
  logic [6:0] evt_s1, evt_s2, evt_p, evt_clr;
  logic [7:0] err_sh [ERR_BYTES];
  logic [7:0] err_lv [ERR_BYTES];
  logic [7:0] scratch [SCR_BYTES];
  logic       seq_ok;
  logic [3:0] seq_nxt;
  logic       blink;
  logic [N_PULSE-1:0] trig, pulses;

  // pulse triggers: 0 eject, 1..3 radio resets
  assign trig[0] = idx_vld && reg_idx == 8'h02;
  assign trig[1] = idx_vld && reg_idx == 8'h20;
  assign trig[2] = idx_vld && reg_idx == 8'h21;
  assign trig[3] = idx_vld && reg_idx == 8'h22;

  generate
    for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
      pmc_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(trig[g]), .pulse(pulses[g]));
    end
  endgenerate

  assign odd_eject = pulses[0];
  assign radio_rst = pulses[3:1];

  pmc_blink #(.DIV(BLINK_DIV)) u_blink (.clk(clk), .rst_n(rst_n), .blink(blink));

  // command side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_pwr   <= 1'b0;
      pwr_mode  <= LED_OFF;
      aux_mode  <= LED_OFF;
      stby_mode <= LED_OFF;
    end else if (idx_vld) begin
      case (reg_idx)
        8'h00: odd_pwr   <= 1'b1;
        8'h01: odd_pwr   <= 1'b0;
        8'h10: pwr_mode  <= LED_ON;
        8'h12: pwr_mode  <= LED_OFF;
        8'h13: pwr_mode  <= LED_BLINK;
        8'h14: aux_mode  <= LED_OFF;
        8'h15: aux_mode  <= LED_ON;
        8'h16: aux_mode  <= LED_BLINK;
        8'h1E: stby_mode <= LED_ON;
        8'h1F: stby_mode <= LED_BLINK;
        default: ;
      endcase
    end
  end

  // event flags: rising edge sets, write-one clears, set wins
  assign evt_clr = (wr_vld && reg_idx == 8'h41) ? wr_data[6:0] : 7'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_s1    <= '0;
      evt_s2    <= '0;
      evt_p     <= '0;
      evt_flags <= '0;
    end else begin
      evt_s1    <= evt_in;
      evt_s2    <= evt_s1;
      evt_p     <= evt_s2;
      evt_flags <= (evt_flags & ~evt_clr) | (evt_s2 & ~evt_p);
    end
  end

  // data registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usb_en  <= '0;
      notif_q <= '0;
      seq_ok  <= 1'b0;
      seq_nxt <= '0;
      for (int i = 0; i < ERR_BYTES; i++) begin
        err_sh[i] <= '0;
        err_lv[i] <= '0;
      end
      for (int i = 0; i < SCR_BYTES; i++) scratch[i] <= '0;
    end else if (wr_vld) begin
      if (reg_idx == 8'h43) usb_en  <= wr_data[1:0];
      if (reg_idx == 8'h44) notif_q <= wr_data;
      if (reg_idx[7]) scratch[reg_idx[6:0]] <= wr_data;
      if (reg_idx[7:4] == 4'h6) begin
        err_sh[reg_idx[3:0]] <= wr_data;
        if (reg_idx[3:0] == 4'hF) begin
          seq_ok  <= 1'b1;
          seq_nxt <= 4'hE;
        end else if (reg_idx[3:0] == 4'h0) begin
          if (seq_ok && seq_nxt == 4'h0) begin
            err_lv[0] <= wr_data;
            for (int i = 1; i < ERR_BYTES; i++) err_lv[i] <= err_sh[i];
          end
          seq_ok <= 1'b0;
        end else if (seq_ok && reg_idx[3:0] == seq_nxt) begin
          seq_nxt <= seq_nxt - 1'b1;
        end else begin
          seq_ok <= 1'b0;
        end
      end
    end
  end

  // read mux
  always_comb begin
    if (is_cmd(reg_idx))              rd_data = 8'hFF;
    else if (reg_idx[7])              rd_data = scratch[reg_idx[6:0]];
    else if (reg_idx[7:4] == 4'h6)    rd_data = err_lv[reg_idx[3:0]];
    else begin
      case (reg_idx)
        8'h40:   rd_data = 8'hC5;
        8'h41:   rd_data = {1'b0, evt_flags};
        8'h43:   rd_data = {6'd0, usb_en};
        8'h44:   rd_data = notif_q;
        8'h47:   rd_data = 8'hFF;
        8'h48:   rd_data = 8'h0F;
        default: rd_data = 8'h00;
      endcase
    end
  end

  assign led_pwr  = led_drive(pwr_mode, blink);
  assign led_aux  = led_drive(aux_mode, blink);
  assign led_stby = led_drive(stby_mode, blink);

  generate
    for (genvar c = 0; c < 3; c++) begin : g_notif
      assign notif_led[c] = notif_q[2*c+1] & (~notif_q[2*c] | blink);
    end
  endgenerate
endmodule

// File: rtl/pwr_mgmt_i2c.sv
module pwr_mgmt_i2c #(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         PULSE_LEN = 16,
  parameter int         BLINK_DIV = 1 << 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] evt_in,
  output logic       odd_pwr,
  output logic       odd_eject,
  output logic [2:0] radio_rst,
  output logic       led_pwr,
  output logic       led_aux,
  output logic       led_stby,
  output logic [2:0] notif_led,
  output logic [1:0] usb_en
);
  logic       idx_vld, wr_vld;
  logic [7:0] wr_data, reg_idx, rd_data;
  logic [6:0] evt_flags;

  pmc_i2c_tgt #(.DEV_ADDR(DEV_ADDR)) u_tgt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .idx_vld(idx_vld), .wr_vld(wr_vld), .wr_data(wr_data),
    .reg_idx(reg_idx), .rd_data(rd_data));

  pmc_regs #(.PULSE_LEN(PULSE_LEN), .BLINK_DIV(BLINK_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_vld(idx_vld), .wr_vld(wr_vld),
    .wr_data(wr_data), .reg_idx(reg_idx), .rd_data(rd_data),
    .evt_in(evt_in), .evt_flags(evt_flags), .odd_pwr(odd_pwr),
    .odd_eject(odd_eject), .radio_rst(radio_rst), .led_pwr(led_pwr),
    .led_aux(led_aux), .led_stby(led_stby), .notif_led(notif_led),
    .usb_en(usb_en));
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       idx_vld,
  input logic       wr_vld,
  input logic [7:0] reg_idx,
  input logic [1:0] usb_en,
  input logic [6:0] evt_flags,
  input logic       odd_pwr,
  input logic       odd_eject,
  input logic [2:0] radio_rst
);
  localparam int CW = $clog2(PULSE_LEN + 1) + 1;
  logic [3:0]    lines;
  logic [CW-1:0] hc [4];

  assign lines = {radio_rst, odd_eject};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 4; i++) hc[i] <= '0;
    else        for (int i = 0; i < 4; i++) hc[i] <= lines[i] ? hc[i] + 1'b1 : '0;
  end

  generate
    for (genvar g = 0; g < 4; g++) begin : g_len
      AST_PULSE_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        hc[g] <= CW'(PULSE_LEN)); // R4
    end
  endgenerate

  AST_SDA_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i); // R12
  AST_DRIVE_BY_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_pwr != $past(odd_pwr)) |-> $past(idx_vld)); // R2
  AST_USB_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_en != $past(usb_en)) |-> $past(wr_vld && reg_idx == 8'h43)); // R8
  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(evt_flags) & ~evt_flags)) |-> $past(wr_vld && reg_idx == 8'h41)); // R7
endmodule

bind pwr_mgmt_i2c pmc_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .idx_vld(idx_vld), .wr_vld(wr_vld), .reg_idx(reg_idx), .usb_en(usb_en),
  .evt_flags(evt_flags), .odd_pwr(odd_pwr), .odd_eject(odd_eject),
  .radio_rst(radio_rst));

// File: tb/pwr_mgmt_i2c_tb.sv
module pwr_mgmt_i2c_tb;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] evt_in = '0;
  logic sda_oe, odd_pwr, odd_eject, led_pwr, led_aux, led_stby;
  logic [2:0] radio_rst, notif_led;
  logic [1:0] usb_en;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pwr_mgmt_i2c #(.PULSE_LEN(16), .BLINK_DIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .evt_in(evt_in), .odd_pwr(odd_pwr), .odd_eject(odd_eject),
    .radio_rst(radio_rst), .led_pwr(led_pwr), .led_aux(led_aux),
    .led_stby(led_stby), .notif_led(notif_led), .usb_en(usb_en));

  // monitors: pulse high-cycle and edge counts, SDA moves while SCL high
  logic [3:0] pl, pl_q = '0;
  int hi [4] = '{0, 0, 0, 0};
  int rs [4] = '{0, 0, 0, 0};
  int oe_bad = 0;
  logic oe_prev = 1'b0;
  assign pl = {radio_rst, odd_eject};
  always @(posedge clk) begin
    pl_q <= pl;
    for (int i = 0; i < 4; i++) begin
      if (pl[i]) hi[i] <= hi[i] + 1;
      if (pl[i] && !pl_q[i]) rs[i] <= rs[i] + 1;
    end
    oe_prev <= sda_oe;
    if (rst_n && scl_m && sda_oe != oe_prev) oe_bad <= oe_bad + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic wbit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
  endtask

  task automatic reg_cmd(input logic [7:0] ix);
    logic a;
    i2c_start(); wbyte(8'hA0, a); wbyte(ix, a); i2c_stop();
  endtask
  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    logic a;
    i2c_start(); wbyte(8'hA0, a); wbyte(ix, a); wbyte(d, a); i2c_stop();
  endtask
  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
    logic a;
    i2c_start(); wbyte(8'hA0, a); wbyte(ix, a);
    i2c_start(); wbyte(8'hA1, a); rbyte(d); wbit(1'b1); i2c_stop();
  endtask

  task automatic watch(output int tp, output int ta, output int ts, output int tn);
    logic p0, a0, s0;
    logic [2:0] n0;
    tp = 0; ta = 0; ts = 0; tn = 0;
    p0 = led_pwr; a0 = led_aux; s0 = led_stby; n0 = notif_led;
    repeat (64) begin
      @(negedge clk);
      if (led_pwr != p0) tp++;
      if (led_aux != a0) ta++;
      if (led_stby != s0) ts++;
      if (notif_led != n0) tn++;
      p0 = led_pwr; a0 = led_aux; s0 = led_stby; n0 = notif_led;
    end
  endtask

  task automatic t_reset();
    chk("R2 reset odd_pwr", odd_pwr, 0);
    chk("R5 reset leds", {led_pwr, led_aux, led_stby}, 0);
    chk("R8 reset usb", usb_en, 0);
    chk("R12 reset sda_oe", sda_oe, 0);
  endtask

  task automatic t_addr();
    logic a;
    i2c_start(); wbyte(8'hA2, a); i2c_stop();
    chk("R1 foreign address nack", a, 0);
    i2c_start(); wbyte(8'hA0, a); i2c_stop();
    chk("R1 own address ack", a, 1);
  endtask

  task automatic t_drive();
    int h0;
    reg_cmd(8'h00); chk("R2 drive on", odd_pwr, 1);
    reg_cmd(8'h01); chk("R2 drive off", odd_pwr, 0);
    h0 = hi[0];
    reg_cmd(8'h02);
    chk("R4 eject pulse length", hi[0] - h0, 16);
  endtask

  task automatic t_radio();
    logic [7:0] ix;
    for (int r = 1; r < 4; r++) begin
      int h [4];
      for (int i = 0; i < 4; i++) h[i] = hi[i];
      ix = 8'h1F + 8'(r);
      reg_cmd(ix);
      for (int i = 0; i < 4; i++)
        chk("R4 radio reset pulse", hi[i] - h[i], (i == r) ? 16 : 0);
    end
  endtask

  task automatic t_cmd_read();
    logic [7:0] d;
    reg_rd(8'h13, d); chk("R3 command index reads FF", d, 8'hFF);
    reg_rd(8'h21, d); chk("R3 command index reads FF", d, 8'hFF);
    reg_wr(8'h30, 8'h5A);
    reg_rd(8'h30, d); chk("R3 undefined index reads 00", d, 8'h00);
  endtask

  task automatic t_led();
    int tp, ta, ts, tn;
    reg_cmd(8'h10); watch(tp, ta, ts, tn);
    chk("R5 power led steady", {31'd0, led_pwr}, 1); chk("R5 power led no toggle", tp, 0);
    reg_cmd(8'h13); watch(tp, ta, ts, tn); chk("R5 power led blinks", tp > 4, 1);
    reg_cmd(8'h12); chk("R5 power led off", led_pwr, 0);
    reg_cmd(8'h15); chk("R5 aux led on", led_aux, 1);
    reg_cmd(8'h16); watch(tp, ta, ts, tn); chk("R5 aux led blinks", ta > 4, 1);
    reg_cmd(8'h14); chk("R5 aux led off", led_aux, 0);
    reg_cmd(8'h1F); watch(tp, ta, ts, tn); chk("R5 standby blinks", ts > 4, 1);
    reg_cmd(8'h1E); watch(tp, ta, ts, tn);
    chk("R5 standby steady on", {31'd0, led_stby}, 1); chk("R5 standby no toggle", ts, 0);
  endtask

  task automatic t_const();
    logic [7:0] d;
    reg_rd(8'h40, d); chk("R6 revision byte", d, 8'hC5);
    reg_rd(8'h47, d); chk("R6 byte 47", d, 8'hFF);
    reg_rd(8'h48, d); chk("R6 byte 48", d, 8'h0F);
    reg_wr(8'h40, 8'h00);
    reg_rd(8'h40, d); chk("R6 revision ignores write", d, 8'hC5);
  endtask

  task automatic t_events();
    logic [7:0] d;
    evt_in[6] = 1'b1; repeat (10) @(negedge clk);
    reg_rd(8'h41, d); chk("R7 power button latched", d, 8'h40);
    reg_wr(8'h41, 8'h40);
    reg_rd(8'h41, d); chk("R7 write one clears, held level no reset", d, 8'h00);
    evt_in[6] = 1'b0; evt_in[3] = 1'b1; evt_in[0] = 1'b1; repeat (10) @(negedge clk);
    evt_in = '0; repeat (10) @(negedge clk);
    reg_rd(8'h41, d); chk("R7 edge flags timer and wake1", d, 8'h09);
    reg_wr(8'h41, 8'h01);
    reg_rd(8'h41, d); chk("R7 partial clear", d, 8'h08);
  endtask

  task automatic t_usb();
    logic [7:0] d;
    reg_wr(8'h43, 8'h03); chk("R8 both ports", usb_en, 2'b11);
    reg_wr(8'h43, 8'hFE); chk("R8 rear only", usb_en, 2'b10);
    reg_rd(8'h43, d); chk("R8 readback masks upper bits", d, 8'h02);
  endtask

  task automatic t_notif();
    logic [7:0] d;
    int tp, ta, ts, tn;
    reg_wr(8'h44, 8'h28); chk("R9 blue and red steady", notif_led, 3'b110);
    reg_wr(8'h44, 8'h30); watch(tp, ta, ts, tn);
    chk("R9 blue blinks", tn > 4, 1); chk("R9 red off", notif_led[1], 0);
    reg_wr(8'h44, 8'hC3); reg_rd(8'h44, d); chk("R9 full byte readback", d, 8'hC3);
  endtask

  task automatic t_err();
    logic [7:0] d;
    reg_rd(8'h65, d); chk("R10 live starts zero", d, 8'h00);
    for (int k = 15; k >= 0; k--) reg_wr(8'h60 + 8'(k), 8'hA0 + 8'(k));
    reg_rd(8'h65, d); chk("R10 descending commit 65", d, 8'hA5);
    reg_rd(8'h60, d); chk("R10 descending commit 60", d, 8'hA0);
    reg_rd(8'h6F, d); chk("R10 descending commit 6F", d, 8'hAF);
    for (int k = 15; k >= 0; k--) if (k != 12) reg_wr(8'h60 + 8'(k), 8'h11);
    reg_rd(8'h65, d); chk("R10 skipped index no commit", d, 8'hA5);
    reg_wr(8'h60, 8'h22);
    reg_rd(8'h60, d); chk("R10 lone low write no commit", d, 8'hA0);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    reg_rd(8'h80, d); chk("R11 scratch resets zero", d, 8'h00);
    reg_wr(8'hFF, 8'hA5); reg_wr(8'h80, 8'h3C);
    reg_rd(8'hFF, d); chk("R11 scratch top", d, 8'hA5);
    reg_rd(8'h80, d); chk("R11 scratch bottom", d, 8'h3C);
  endtask

  task automatic t_extra();
    logic a1, a2, a3, a4;
    logic [7:0] d;
    i2c_start(); wbyte(8'hA0, a1); wbyte(8'h90, a2); wbyte(8'h77, a3); wbyte(8'h88, a4); i2c_stop();
    chk("R13 first data acked", a3, 1);
    chk("R13 second data nacked", a4, 0);
    reg_rd(8'h90, d); chk("R13 first data kept", d, 8'h77);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_drive();
    t_radio();
    t_cmd_read();
    t_led();
    t_const();
    t_events();
    t_usb();
    t_notif();
    t_err();
    t_scratch();
    t_extra();
    chk("R12 sda drive changed while scl high", oe_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule